// File: doc/BRIEF.md
# Quarter-Wave Sine Tone Generator

This block synthesizes a signed sine tone from a running phase. A wide phase register grows by a programmable tuning word on every cycle in which the clock-enable is high. The upper phase bits then pick a magnitude from a table that covers only the first quarter of a period. The two highest phase bits work out which quarter the phase lies in. One bit reflects the table address, so the falling half of each lobe reads the table backwards. The other bit flips the sign of the value, so the second half-period is the negative of the first.

Samples leave on a stream-style master port as a data word and a valid flag. A ready input is also present. The generator is a free-running source and never waits on ready, so a consumer must take each sample in the cycle that valid marks it.

The tone frequency is f_out = tune × f_clk / 2^32. With a 100 MHz clock, a tuning word of 51539608 gives about 1.2 MHz and 57982058 gives about 1.35 MHz. Holding the enable high gives one sample per clock. A slower sample rate comes from pulsing the enable.

Top module: `qsine_dds`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `m_axis_tvalid` is 0 and `m_axis_tdata` is 0. Reset clears the phase register to 0, so the first valid sample after reset is 0.
- R2: Each rising clock edge with `clk_en` high adds `tune_word` to the 32-bit phase register. The sum wraps modulo 2^32.
- R3: A sample is made from the phase held before the enabled edge. Bits [29:22] form an index i. When bit 30 is 1, the address is 255 − i; otherwise it is i. When bit 31 is 1, the sample is the negated table value; otherwise it is the table value itself.
- R4: Table entry a (0..255) is round(127 × sin(π × (a + 0.5) / 512)), a value from 0 to 127. The output therefore always lies in −127..127 and is never −128.
- R5: With `clk_en` held high, a new sample appears after every clock edge. For tuning word 2^30 the samples after reset are 0, 127, 0 and −127, and the sequence then repeats.
- R6: `m_axis_tvalid` is 1 in the cycle after an edge where `clk_en` was 1, and 0 after an edge where it was 0. During disabled cycles the phase and the data hold their values.
- R7: `m_axis_tready` has no effect on the output. Samples and valid behave the same whether it is 0 or 1.
- R8: When the phase passes 2^32 − 1 it wraps around, and the sample sequence continues without a break. A tuning word of 0xFFFFFFFF steps the phase backwards by one count per enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Advance enable, one strobe per output sample |
| tune_word | input | 32 | Phase increment added per enabled cycle |
| m_axis_tvalid | output | 1 | Sample valid flag |
| m_axis_tdata | output | 8 | Signed two's-complement sine sample |
| m_axis_tready | input | 1 | Downstream ready; accepted and not acted on |

## Verification
Several properties are checked on every clock edge. The phase and the data freeze while the enable is low. The phase moves whenever a nonzero word is applied. Valid tracks the enable, whatever ready is. A phase in the negative half-period never yields a positive sample, and the sample −128 never appears.

The exact sample values can only be shown by the bench's scenarios, which compare each sample with a model built from the table formula. These scenarios cover the following cases:
- the sample values at the quadrant boundaries;
- the tones near 1.2 MHz and 1.35 MHz;
- wrap-around of the phase;
- the zero first sample after reset;
- random patterns of enable and ready.

// File: rtl/qsine_pkg.sv
package qsine_pkg;

   localparam real QS_PI = 3.14159265358979;

   // Rounded quarter-period sine magnitude for table slot idx.
   // The half-slot offset makes the reflected address land on a
   // symmetric value.
   function automatic int quarter_sine(input int idx, input int addr_w, input int mag_w);
      real amp;
      real ang;
      amp = real'((1 << mag_w) - 1);
      ang = QS_PI * (real'(idx) + 0.5) / real'(2 * (1 << addr_w));
      return $rtoi(amp * $sin(ang) + 0.5);
   endfunction

endpackage

// File: rtl/qsine_phase_acc.sv
module qsine_phase_acc #(
   parameter int PHASE_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic [PHASE_W-1:0] step,
   output logic [PHASE_W-1:0] phase
);

   always_ff @(posedge clk) begin
      if (rst)
         phase <= '0;
      else if (en)
         phase <= phase + step;
   end

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(phase));                                   // R6

   AST_PHASE_MOVES: assert property (@(posedge clk) disable iff (rst)
      (en && step != '0) |=> phase != $past(phase));             // R2

endmodule

// File: rtl/qsine_quarter_rom.sv
module qsine_quarter_rom #(
   parameter int ADDR_W = 8,
   parameter int MAG_W  = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [ADDR_W+1:0] phase_hi,
   output logic [MAG_W:0]    sample
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int OUT_W = MAG_W + 1;

   logic [MAG_W-1:0] mag_tab [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_tab
      localparam logic [MAG_W-1:0] ENTRY = MAG_W'(qsine_pkg::quarter_sine(g, ADDR_W, MAG_W));
      assign mag_tab[g] = ENTRY;
   end

   logic              neg_half;
   logic              reflect;
   logic [ADDR_W-1:0] idx;
   logic [ADDR_W-1:0] addr;
   logic [MAG_W-1:0]  mag;
   logic [OUT_W-1:0]  pos_val;
   logic [OUT_W-1:0]  signed_val;

   always_comb begin
      neg_half   = phase_hi[ADDR_W+1];
      reflect    = phase_hi[ADDR_W];
      idx        = phase_hi[ADDR_W-1:0];
      addr       = reflect ? ~idx : idx;
      mag        = mag_tab[addr];
      pos_val    = {1'b0, mag};
      signed_val = neg_half ? (~pos_val + 1'b1) : pos_val;
   end

   always_ff @(posedge clk) begin
      if (rst)
         sample <= '0;
      else if (en)
         sample <= signed_val;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      sample != {1'b1, {MAG_W{1'b0}}});                          // R4

   AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(sample));                                  // R6

endmodule

// File: rtl/qsine_dds.sv
module qsine_dds #(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 8,
   parameter int MAG_W   = 7
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               clk_en,
   input  logic [PHASE_W-1:0] tune_word,
   output logic               m_axis_tvalid,
   output logic [MAG_W:0]     m_axis_tdata,
   input  logic               m_axis_tready
);

   localparam int HI_W = ADDR_W + 2;

   if (PHASE_W < HI_W) begin : g_bad_phase
      $error("qsine_dds: PHASE_W must cover ADDR_W plus two quadrant bits");
   end
   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("qsine_dds: ADDR_W out of supported range");
   end
   if (MAG_W < 2 || MAG_W > 24) begin : g_bad_mag
      $error("qsine_dds: MAG_W out of supported range");
   end

   logic [PHASE_W-1:0] phase;
   logic               valid_q;

   qsine_phase_acc #(.PHASE_W(PHASE_W)) i_acc (
      .clk   (clk),
      .rst   (rst),
      .en    (clk_en),
      .step  (tune_word),
      .phase (phase)
   );

   qsine_quarter_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) i_rom (
      .clk      (clk),
      .rst      (rst),
      .en       (clk_en),
      .phase_hi (phase[PHASE_W-1 -: HI_W]),
      .sample   (m_axis_tdata)
   );

   always_ff @(posedge clk) begin
      if (rst)
         valid_q <= 1'b0;
      else
         valid_q <= clk_en;
   end

   assign m_axis_tvalid = valid_q;

   AST_VALID_ON_EN: assert property (@(posedge clk) disable iff (rst)
      clk_en |=> m_axis_tvalid);                                 // R6

   AST_NO_STALL: assert property (@(posedge clk) disable iff (rst)
      (clk_en && !m_axis_tready) |=> m_axis_tvalid);             // R7

   AST_NEG_HALF: assert property (@(posedge clk) disable iff (rst)
      (clk_en && phase[PHASE_W-1]) |=> !(|m_axis_tdata) || m_axis_tdata[MAG_W]); // R3

   AST_POS_HALF: assert property (@(posedge clk) disable iff (rst)
      (clk_en && !phase[PHASE_W-1]) |=> !m_axis_tdata[MAG_W]);   // R3

endmodule

// File: tb/test_qsine_dds.sv
module test_qsine_dds;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        clk_en = 1'b0;
   logic [31:0] tune_word = '0;
   logic        m_axis_tready = 1'b1;
   logic        m_axis_tvalid;
   logic [7:0]  m_axis_tdata;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [31:0]       m_phase;
   logic signed [7:0] exp_data;
   logic              exp_valid;

   always #4 clk = ~clk;

   qsine_dds i_qsine_dds (
      .clk           (clk),
      .rst           (rst),
      .clk_en        (clk_en),
      .tune_word     (tune_word),
      .m_axis_tvalid (m_axis_tvalid),
      .m_axis_tdata  (m_axis_tdata),
      .m_axis_tready (m_axis_tready)
   );

   function automatic logic signed [7:0] ref_sample(input logic [31:0] ph);
      int  i;
      int  m;
      real a;
      i = int'(ph[29:22]);
      if (ph[30]) i = 255 - i;
      a = 3.14159265358979 * (real'(i) + 0.5) / 512.0;
      m = $rtoi(127.0 * $sin(a) + 0.5);
      if (ph[31]) m = -m;
      return 8'(m);
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
      n_cmp++;
      if (act !== exp_v) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, $signed(act), $signed(exp_v));
      end
   endtask

   // Checks outputs from the previous edge, then drives inputs and predicts the next edge.
   task automatic cycle(input string tag, input logic en, input logic [31:0] tw, input logic rdy);
      @(negedge clk);
      check({tag, " valid"}, {7'd0, m_axis_tvalid}, {7'd0, exp_valid});
      check({tag, " data"}, m_axis_tdata, exp_data);
      clk_en        = en;
      tune_word     = tw;
      m_axis_tready = rdy;
      if (en) begin
         exp_data  = ref_sample(m_phase);
         exp_valid = 1'b1;
         m_phase   = m_phase + tw;
      end else begin
         exp_valid = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst    = 1'b1;
      clk_en = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset valid", {7'd0, m_axis_tvalid}, 8'd0);
      check("R1 reset data", m_axis_tdata, 8'd0);
      rst       = 1'b0;
      m_phase   = '0;
      exp_data  = '0;
      exp_valid = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      m_phase   = '0;
      exp_data  = '0;
      exp_valid = 1'b0;

      // R1: first valid sample after reset is zero
      do_reset();
      cycle("R1 first", 1'b1, 32'h4000_0000, 1'b1);
      @(negedge clk);
      check("R1 first valid", {7'd0, m_axis_tvalid}, 8'd1);
      check("R1 first sample zero", m_axis_tdata, 8'd0);

      // R5: quadrant corners with a quarter-period step (0,127,0,-127)
      do_reset();
      m_phase = '0;
      clk_en = 1'b1;
      tune_word = 32'h4000_0000;
      @(negedge clk);
      check("R5 q0", m_axis_tdata, 8'd0);
      @(negedge clk);
      check("R5 q1", m_axis_tdata, 8'd127);
      @(negedge clk);
      check("R5 q2", m_axis_tdata, 8'd0);
      @(negedge clk);
      check("R5 q3", m_axis_tdata, 8'h81);
      @(negedge clk);
      check("R5 repeat", m_axis_tdata, 8'd0);

      // R2, R3: tone near 1.2 MHz at a 100 MHz clock
      do_reset();
      for (int k = 0; k < 300; k++) cycle("R2 tone1", 1'b1, 32'd51539608, 1'b1);
      // R3, R4: tone near 1.35 MHz
      for (int k = 0; k < 300; k++) cycle("R3 tone2", 1'b1, 32'd57982058, 1'b1);
      // R4: fine step that visits every table slot
      for (int k = 0; k < 1100; k++) cycle("R4 sweep", 1'b1, 32'h0040_0000, 1'b1);

      // R8: backwards step across the wrap point, then a large forward step
      do_reset();
      for (int k = 0; k < 40; k++) cycle("R8 backward", 1'b1, 32'hFFFF_FFFF, 1'b1);
      for (int k = 0; k < 200; k++) cycle("R8 wrap", 1'b1, 32'hF000_0123, 1'b1);

      // R6: gated enable holds data and drops valid
      for (int k = 0; k < 400; k++)
         cycle("R6 gated", 1'($urandom_range(0, 2) == 0), 32'd57982058, 1'b1);

      // R7: ready held low, then random ready with random enable and word
      for (int k = 0; k < 200; k++) cycle("R7 ready low", 1'b1, 32'd51539608, 1'b0);
      for (int k = 0; k < 1500; k++)
         cycle("R7 random", 1'($urandom_range(0, 1)), $urandom, 1'($urandom_range(0, 1)));

      // R1: reset in mid-run
      do_reset();
      cycle("R1 rerun", 1'b1, $urandom, 1'b0);
      cycle("R1 rerun", 1'b1, $urandom, 1'b1);
      @(negedge clk);
      check("R1 rerun valid", {7'd0, m_axis_tvalid}, {7'd0, exp_valid});
      check("R1 rerun data", m_axis_tdata, exp_data);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule